// File: doc/BRIEF.md
# Static Memory Bus Controller

This block connects an internal request port, which carries byte, halfword and word transfers, to an external asynchronous bus for SRAM, ROM and flash parts. Address bits above the 25-bit device offset select one of eight active-low chip enables. Each chip-enable region has its own configuration inputs: the data width on the pins (8 or 16 bits), how individual bytes are selected, and a wait count of 0 to 7 cycles.

A request wider than the region's data bus is split into several external cycles in little-endian order, with the lowest address first. Every external cycle keeps its strobes asserted for the programmed wait count plus one cycle. A device can stretch that final cycle with its wait pin. Every external cycle is followed by one cycle in which all strobes are released. In the released cycle after the last external cycle, the requester receives a one-cycle acknowledge. For reads, the assembled data arrives with that acknowledge.

Top module: `smem_ctrl`

## Requirements
- R1: During an external cycle exactly one bit of `mem_ce_n` is low, and its index is `req_addr[27:25]` of the accepted request. Outside external cycles all bits of `mem_ce_n` are high.
- R2: `mem_addr` equals `req_addr[24:0]` plus the beat offset: 2 bytes per beat on a 16-bit region and 1 byte per beat on an 8-bit region. On a 16-bit region in strobe mode, bit 0 is driven 0. The address is held steady for the whole external cycle.
- R3: `req_size` is encoded as 0 for a byte, 1 for a halfword and 2 for a word. A 16-bit region takes 1, 1 or 2 external cycles for these sizes. An 8-bit region takes 1, 2 or 4. The lowest address always goes first.
- R4: Each external cycle holds its strobe low for W+1 clock cycles, where W is the region's 3-bit field `cfg_wait[3*i+2:3*i]`. With N beats, `rsp_ack` is high in the N*(W+2)-1th cycle after the accepting clock edge.
- R5: A high `mem_wait` extends an external cycle by one clock for each cycle it is sampled high after the wait count is used up. While the count is still running, `mem_wait` has no effect.
- R6: All chip enables and strobes are high for at least one cycle after every external cycle, both between beats and after the last beat.
- R7: Read data on `rsp_rdata` is right-justified and assembled little-endian, and its unused upper bits are 0. On an 8-bit region only `mem_din[7:0]` is used. A byte read from a 16-bit region takes lane [15:8] for odd addresses and lane [7:0] for even addresses.
- R8: Write data on a 16-bit region puts halfword k of a word on beat k, and a byte is copied onto both lanes. On an 8-bit region, byte k goes on `mem_dout[7:0]` and `mem_dout[15:8]` is 0. `mem_dout_en` is high only while `mem_wr_n` is low, and `mem_rd_n` and `mem_wr_n` are never low together.
- R9: When `cfg_bstrobe[i]` is 1 (strobe mode), `mem_bs_n` is active low with bit 0 for lane [7:0] and bit 1 for lane [15:8]. An 8-bit region drives 2'b10. On a 16-bit region, a byte access drives the single lane it uses and wider accesses drive 2'b00. When `cfg_bstrobe[i]` is 0 (A0 mode), `mem_bs_n` stays 2'b11 and `mem_addr[0]` carries the byte address. Outside external cycles `mem_bs_n` is 2'b11.
- R10: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `rsp_ack` is a single-cycle pulse.
- R11: While reset is asserted, all chip enables and strobes are high, `mem_dout_en` is 0, `req_ready` is 1 and `rsp_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 28 | [27:25] region, [24:0] device byte offset |
| req_wdata | input | 32 | Right-justified write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-justified read data, valid with rsp_ack |
| cfg_bus16 | input | 8 | Per region: 1 = 16-bit bus, 0 = 8-bit |
| cfg_bstrobe | input | 8 | Per region: 1 = byte strobes, 0 = A0 addressing |
| cfg_wait | input | 24 | Per region 3-bit wait count |
| mem_ce_n | output | 8 | Chip enables, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_bs_n | output | 2 | Byte strobes, active low |
| mem_addr | output | 25 | External byte address |
| mem_dout | output | 16 | Write data to pins |
| mem_dout_en | output | 1 | Output enable for write data |
| mem_din | input | 16 | Read data from pins |
| mem_wait | input | 1 | Device wait request, active high |

## Verification
The hardest case to reach from the ports is the interaction between the device wait pin and the internal count. The pin must stretch a beat only once the count has run out. The bench drives `mem_wait` from a process that watches the strobes at the falling edge and raises the pin for a set number of strobe-active cycles. Applied to a region with a zero wait count, every cycle of it must add latency. Applied to a region with a wait count of seven, the same burst must add none. The bench's device model returns a byte pattern derived from the address, and it returns 0xFF on the unused lane of 8-bit regions. This exposes any lane or ordering error in the assembled read data, as well as any upper bits that are not cleared.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_GAP    = 2'd2
  } state_e;

  // Index of the last beat for a transfer size on a given bus width
  function automatic logic [1:0] last_beat(size_e sz, logic w16);
    logic [1:0] r;
    case (sz)
      SZ_HALF: r = w16 ? 2'd0 : 2'd1;
      SZ_WORD: r = w16 ? 2'd1 : 2'd3;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/smem_decode.sv
module smem_decode
  import smem_pkg::*;
#(
  parameter int NUM_CE = 8,
  parameter int ADDR_W = 25,
  parameter int WAIT_W = 3,
  localparam int CE_W  = $clog2(NUM_CE)
) (
  input  logic [ADDR_W+CE_W-1:0]   addr,
  input  size_e                    size,
  input  logic [NUM_CE-1:0]        cfg_bus16,
  input  logic [NUM_CE-1:0]        cfg_bstrobe,
  input  logic [NUM_CE*WAIT_W-1:0] cfg_wait,
  output logic [CE_W-1:0]          ce_idx,
  output logic                     w16,
  output logic                     bstr,
  output logic [WAIT_W-1:0]        wait_cnt,
  output logic [1:0]               last
);

  always_comb begin
    ce_idx   = addr[ADDR_W+CE_W-1:ADDR_W];
    w16      = cfg_bus16[ce_idx];
    bstr     = cfg_bstrobe[ce_idx];
    wait_cnt = cfg_wait[ce_idx*WAIT_W +: WAIT_W];
    last     = last_beat(size, w16);
  end

endmodule

// File: rtl/smem_wait_timer.sv
module smem_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  input  logic              ext_wait,
  output logic              done
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // The beat ends once the count is spent and the device is not holding off
  assign done = run && (cnt_q == '0) && !ext_wait;

endmodule

// File: rtl/smem_lane.sv
module smem_lane
  import smem_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic [ADDR_W-1:0] addr_base,
  input  logic [1:0]        beat,
  input  size_e             size,
  input  logic              w16,
  input  logic              bstr,
  input  logic [31:0]       wdata,
  input  logic [15:0]       din,
  input  logic [31:0]       acc_in,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [15:0]       dout,
  output logic [1:0]        bs_n,
  output logic [31:0]       acc_out
);

  logic [2:0] offset;

  always_comb begin
    offset   = w16 ? {beat, 1'b0} : {1'b0, beat};
    ext_addr = addr_base + {{(ADDR_W-3){1'b0}}, offset};
    if (w16 && bstr) ext_addr[0] = 1'b0;
  end

  always_comb begin
    if (w16) begin
      if (size == SZ_BYTE) dout = {wdata[7:0], wdata[7:0]};
      else if (beat[0])    dout = wdata[31:16];
      else                 dout = wdata[15:0];
    end else begin
      dout = {8'h00, wdata[{beat, 3'b000} +: 8]};
    end
  end

  always_comb begin
    if (!bstr)                bs_n = 2'b11;
    else if (!w16)            bs_n = 2'b10;
    else if (size == SZ_BYTE) bs_n = addr_base[0] ? 2'b01 : 2'b10;
    else                      bs_n = 2'b00;
  end

  always_comb begin
    acc_out = acc_in;
    if (w16) begin
      if (size == SZ_BYTE) acc_out[7:0]   = addr_base[0] ? din[15:8] : din[7:0];
      else if (beat[0])    acc_out[31:16] = din;
      else                 acc_out[15:0]  = din;
    end else begin
      acc_out[{beat, 3'b000} +: 8] = din[7:0];
    end
  end

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_pkg::*;
#(
  parameter int NUM_CE = 8,
  parameter int ADDR_W = 25,
  parameter int WAIT_W = 3,
  localparam int CE_W  = $clog2(NUM_CE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W+CE_W-1:0]   req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_ack,
  output logic [31:0]              rsp_rdata,
  input  logic [NUM_CE-1:0]        cfg_bus16,
  input  logic [NUM_CE-1:0]        cfg_bstrobe,
  input  logic [NUM_CE*WAIT_W-1:0] cfg_wait,
  output logic [NUM_CE-1:0]        mem_ce_n,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n,
  output logic [1:0]               mem_bs_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [15:0]              mem_dout,
  output logic                     mem_dout_en,
  input  logic [15:0]              mem_din,
  input  logic                     mem_wait
);

  state_e              state_q, state_d;
  logic [CE_W-1:0]     r_ce;
  logic [ADDR_W-1:0]   r_addr;
  size_e               r_size;
  logic                r_write, r_w16, r_bstr;
  logic [WAIT_W-1:0]   r_wait;
  logic [31:0]         r_wdata;
  logic [1:0]          beat_q, beat_d, last_q;
  logic [31:0]         acc_q, acc_next;

  logic [CE_W-1:0]     dec_ce;
  logic                dec_w16, dec_bstr;
  logic [WAIT_W-1:0]   dec_wait;
  logic [1:0]          dec_last;

  logic                accept, more, in_access, in_gap, beat_done;
  logic                tmr_load, beat_en, acc_en;
  logic [WAIT_W-1:0]   tmr_val;
  logic [1:0]          lane_bs;

  smem_decode #(.NUM_CE(NUM_CE), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dec (
    .addr        (req_addr),
    .size        (size_e'(req_size)),
    .cfg_bus16   (cfg_bus16),
    .cfg_bstrobe (cfg_bstrobe),
    .cfg_wait    (cfg_wait),
    .ce_idx      (dec_ce),
    .w16         (dec_w16),
    .bstr        (dec_bstr),
    .wait_cnt    (dec_wait),
    .last        (dec_last)
  );

  assign in_access = (state_q == ST_ACCESS);
  assign in_gap    = (state_q == ST_GAP);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign more      = in_gap && (beat_q != last_q);
  assign tmr_load  = accept || more;
  assign tmr_val   = accept ? dec_wait : r_wait;

  smem_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (in_access),
    .ext_wait (mem_wait),
    .done     (beat_done)
  );

  smem_lane #(.ADDR_W(ADDR_W)) u_lane (
    .addr_base (r_addr),
    .beat      (beat_q),
    .size      (r_size),
    .w16       (r_w16),
    .bstr      (r_bstr),
    .wdata     (r_wdata),
    .din       (mem_din),
    .acc_in    (acc_q),
    .ext_addr  (mem_addr),
    .dout      (mem_dout),
    .bs_n      (lane_bs),
    .acc_out   (acc_next)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_ACCESS;
      ST_ACCESS: if (beat_done) state_d = ST_GAP;
      ST_GAP:    state_d = more ? ST_ACCESS : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_en = accept || more;
    beat_d  = accept ? 2'd0 : beat_q + 2'd1;
    acc_en  = accept || (beat_done && !r_write);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_ce    <= '0;
      r_addr  <= '0;
      r_size  <= SZ_BYTE;
      r_write <= 1'b0;
      r_w16   <= 1'b0;
      r_bstr  <= 1'b0;
      r_wait  <= '0;
      r_wdata <= '0;
      last_q  <= '0;
    end else if (accept) begin
      r_ce    <= dec_ce;
      r_addr  <= req_addr[ADDR_W-1:0];
      r_size  <= size_e'(req_size);
      r_write <= req_write;
      r_w16   <= dec_w16;
      r_bstr  <= dec_bstr;
      r_wait  <= dec_wait;
      r_wdata <= req_wdata;
      last_q  <= dec_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= accept ? 32'h0 : acc_next;
  end

  // Pin drive, all derived from registered state
  assign mem_ce_n    = in_access ? ~(NUM_CE'(1) << r_ce) : '1;
  assign mem_rd_n    = !(in_access && !r_write);
  assign mem_wr_n    = !(in_access && r_write);
  assign mem_dout_en = in_access && r_write;
  assign mem_bs_n    = in_access ? lane_bs : 2'b11;
  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_ack     = in_gap && (beat_q == last_q);
  assign rsp_rdata   = acc_q;

endmodule

// File: rtl/smem_ctrl_chk.sv
module smem_ctrl_chk #(
  parameter int NUM_CE = 8,
  parameter int ADDR_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_ack,
  input logic [NUM_CE-1:0] mem_ce_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic [1:0]        mem_bs_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dout_en,
  input logic              mem_wait
);

  logic act;
  assign act = !mem_rd_n || !mem_wr_n;

  // R1
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  // R1
  ce_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> ($countones(~mem_ce_n) == 1));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> $stable(mem_addr));

  // R5
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mem_wait) |=> act);

  // R6
  idle_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> ((&mem_ce_n) && mem_rd_n && mem_wr_n));

  // R8
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  // R8
  dout_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> !mem_wr_n);

  // R9
  bs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (&mem_bs_n));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !act);

endmodule

bind smem_ctrl smem_ctrl_chk #(.NUM_CE(NUM_CE), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_ack     (rsp_ack),
  .mem_ce_n    (mem_ce_n),
  .mem_rd_n    (mem_rd_n),
  .mem_wr_n    (mem_wr_n),
  .mem_bs_n    (mem_bs_n),
  .mem_addr    (mem_addr),
  .mem_dout_en (mem_dout_en),
  .mem_wait    (mem_wait)
);

// File: tb/smem_ctrl_bench.sv
`timescale 1ns/1ps
module smem_ctrl_bench;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [27:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_ack;
  logic [7:0]  cfg_bus16, cfg_bstrobe, mem_ce_n;
  logic [23:0] cfg_wait;
  logic        mem_rd_n, mem_wr_n, mem_dout_en, mem_wait;
  logic [1:0]  mem_bs_n;
  logic [24:0] mem_addr;
  logic [15:0] mem_dout, mem_din;

  int n_chk = 0;
  int n_fail = 0;

  smem_ctrl u_smem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .cfg_bus16(cfg_bus16), .cfg_bstrobe(cfg_bstrobe), .cfg_wait(cfg_wait),
    .mem_ce_n(mem_ce_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait(mem_wait)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Region setup: r0 16/A0/W0, r1 8/strobe/W2, r2 16/strobe/W7, r3 8/A0/W1, r4-7 16/strobe/W3
  localparam logic [7:0]  BUS16 = 8'b1111_0101;
  localparam logic [7:0]  BSTR  = 8'b1111_0110;
  localparam logic [23:0] WAITS = {3'd3, 3'd3, 3'd3, 3'd3, 3'd1, 3'd7, 3'd2, 3'd0};

  function automatic logic [7:0] pat(input logic [24:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int nbeats(input logic [1:0] sz, input logic w16);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return w16 ? 1 : 2;
    return w16 ? 2 : 4;
  endfunction

  // Device model: address-derived bytes, 0xFF on the unused lane of 8-bit parts
  logic act_now;
  int   act_rg;
  always_comb begin
    act_rg = 0;
    for (int i = 0; i < 8; i++) if (!mem_ce_n[i]) act_rg = i;
    act_now = !(&mem_ce_n);
    if (!act_now)                mem_din = 16'hDEAD;
    else if (BUS16[act_rg])      mem_din = {pat({mem_addr[24:1], 1'b1}), pat({mem_addr[24:1], 1'b0})};
    else                         mem_din = {8'hFF, pat(mem_addr)};
  end

  // Beat monitor and wait-pin driver
  logic [24:0] lg_addr [4];
  logic [15:0] lg_dout [4];
  logic [1:0]  lg_bs   [4];
  int          lg_cnt;
  logic        prev_act;
  int          wait_budget;
  always @(negedge clk) begin
    logic a;
    a = act_now && (!mem_rd_n || !mem_wr_n);
    if (a && lg_cnt < 4) begin
      lg_addr[lg_cnt] = mem_addr;
      lg_dout[lg_cnt] = mem_dout;
      lg_bs[lg_cnt]   = mem_bs_n;
    end
    if (prev_act && !a) lg_cnt = lg_cnt + 1;
    prev_act = a;
    if (a && wait_budget > 0) begin
      mem_wait    = 1'b1;
      wait_budget = wait_budget - 1;
    end else begin
      mem_wait = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One transaction with full checks; extra = expected added latency
  task automatic run_req(input logic [2:0] rg, input logic wr, input logic [1:0] sz,
                         input logic [7:0] aoff, input logic [31:0] wd, input int extra,
                         input int wbud);
    logic [24:0] base;
    logic [31:0] exp_rd, got_rd;
    int nb, w, lat;
    logic w16, bs;
    base = {9'h155, 8'h00, aoff};
    w16  = BUS16[rg];
    bs   = BSTR[rg];
    w    = int'(WAITS[rg*3 +: 3]);
    nb   = nbeats(sz, w16);
    @(negedge clk);
    lg_cnt = 0;
    wait_budget = wbud;
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = {rg, base}; req_wdata = wd;
    @(posedge clk);
    lat = 0;
    got_rd = '0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (lat == 0) chk(!req_ready, "R10 ready low while busy", {31'h0, req_ready}, 32'h0);
      if (rsp_ack) begin
        got_rd = rsp_rdata;
        chk((&mem_ce_n) && mem_rd_n && mem_wr_n, "R6 strobes idle at ack",
            {22'h0, mem_ce_n, mem_rd_n, mem_wr_n}, {22'h0, 8'hFF, 2'b11});
        break;
      end
      lat++;
      if (lat > 400) break;
    end
    @(negedge clk);
    chk(!rsp_ack, "R10 ack single pulse", {31'h0, rsp_ack}, 32'h0);
    chk(lat == nb*(w+2)-1+extra, "R4/R5 ack latency", lat, nb*(w+2)-1+extra);
    chk(lg_cnt == nb, "R3 beat count", lg_cnt, nb);
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < (1 << sz); i++) exp_rd[8*i +: 8] = pat(base + 25'(i));
      chk(got_rd == exp_rd, "R7 read data", got_rd, exp_rd);
    end
    for (int k = 0; k < nb && k < 4; k++) begin
      logic [24:0] ea;
      logic [15:0] ed;
      logic [1:0]  eb;
      ea = base + 25'(w16 ? 2*k : k);
      if (w16 && bs) ea[0] = 1'b0;
      chk(lg_addr[k] == ea, "R2 beat address", {7'h0, lg_addr[k]}, {7'h0, ea});
      if (!bs)             eb = 2'b11;
      else if (!w16)       eb = 2'b10;
      else if (sz == 2'd0) eb = base[0] ? 2'b01 : 2'b10;
      else                 eb = 2'b00;
      chk(lg_bs[k] == eb, "R9 byte strobes", {30'h0, lg_bs[k]}, {30'h0, eb});
      if (wr) begin
        if (w16) ed = (sz == 2'd0) ? {wd[7:0], wd[7:0]} : wd[16*k +: 16];
        else     ed = {8'h00, wd[8*k +: 8]};
        chk(lg_dout[k] == ed, "R8 write lanes", {16'h0, lg_dout[k]}, {16'h0, ed});
      end
    end
  endtask

  // {region, write, size, addr offset, wdata}
  localparam int NV = 12;
  localparam logic [NV-1:0][45:0] VEC = '{
    {3'd0, 1'b0, 2'd2, 8'h10, 32'h0},
    {3'd0, 1'b1, 2'd2, 8'h20, 32'h11223344},
    {3'd1, 1'b0, 2'd2, 8'h04, 32'h0},
    {3'd1, 1'b1, 2'd1, 8'h06, 32'h0000BEEF},
    {3'd2, 1'b0, 2'd0, 8'h33, 32'h0},
    {3'd2, 1'b1, 2'd0, 8'h35, 32'h000000A7},
    {3'd3, 1'b0, 2'd1, 8'h0A, 32'h0},
    {3'd3, 1'b1, 2'd0, 8'h0B, 32'h0000005C},
    {3'd0, 1'b0, 2'd0, 8'h41, 32'h0},
    {3'd2, 1'b1, 2'd2, 8'h80, 32'hCAFEF00D},
    {3'd5, 1'b0, 2'd1, 8'h12, 32'h0},
    {3'd1, 1'b0, 2'd0, 8'h07, 32'h0}
  };

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; mem_wait = 1'b0;
    cfg_bus16 = BUS16; cfg_bstrobe = BSTR; cfg_wait = WAITS;
    lg_cnt = 0; prev_act = 1'b0; wait_budget = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(&mem_ce_n, "R11 ce_n high in reset", {24'h0, mem_ce_n}, 32'hFF);
    chk(mem_rd_n && mem_wr_n && !mem_dout_en, "R11 strobes idle in reset",
        {29'h0, mem_rd_n, mem_wr_n, mem_dout_en}, 32'h6);
    chk(req_ready && !rsp_ack, "R11 ready/ack in reset", {30'h0, req_ready, rsp_ack}, 32'h2);
    chk(mem_bs_n == 2'b11, "R9 bs_n idle in reset", {30'h0, mem_bs_n}, 32'h3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready, "R10 ready when idle", {31'h0, req_ready}, 32'h1);

    // Table walk: R1 region select is implied by the per-region model and latency
    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      e = VEC[NV-1-v];
      run_req(e[45:43], e[42], e[41:40], e[39:32], e[31:0], 0, 0);
    end

    // R5: wait pin adds three cycles once a zero count is spent
    run_req(3'd0, 1'b0, 2'd2, 8'h50, 32'h0, 3, 3);
    // R5: wait pin during a running count of seven has no effect
    run_req(3'd2, 1'b0, 2'd0, 8'h61, 32'h0, 0, 5);

    // R1: chip enable index follows the region field
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = {3'd6, 25'h0000123};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_ce_n == 8'hBF, "R1 chip enable select", {24'h0, mem_ce_n}, 32'hBF);
    while (!rsp_ack) @(negedge clk);
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule